// File: doc/BRIEF.md
# Linked page-table address translator

This block turns bus addresses into physical addresses by walking a chain of 4 KB table pages in memory. Each table page covers 1 MB of input space. It holds 256 data-page pointers in its lower half. Its last two 64-bit slots link back to the previous table and forward to the next one. An entry is valid only when its bit 0 is set. To reach a table other than the one it last used, the walker follows these links one table at a time. It keeps the address and number of the current table from one request to the next, so a run of nearby addresses needs a single entry read each.

A small register set holds the table base, the input base, the mode and the enable bit, and reports a ready status. In pass-through mode a request is answered with its own address and no memory is read. One translation is outstanding at a time. A lookup that meets an invalid entry or an invalid link returns a fault.

Top module: `chain_xlat`

## Requirements
- R1: After reset, rsp_valid and mem_req are low, stat_ready is high, req_ready is low, and every register reads zero except the ready bit (mode 0 means pass-through).
- R2: Register select 0 is the table base (bits 11:0 read zero), 1 is the input base (bits 19:0 read zero), 2 bit 0 is the mode (1 = translate), 3 bit 0 is enable and bit 1 is ready (read only); writes to selects 0 to 2 are ignored while enable is 1.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both high; req_ready is high only when enabled and no translation is in flight.
- R4: In pass-through mode the response follows in the cycle after acceptance, with rsp_addr equal to the request address, rsp_fault low and no memory read.
- R5: In translate mode, with offset = address minus input base, the table number is offset bits above 19 and the entry index is offset bits 19:12. The entry is read at table address + 8 x index, and rsp_addr is entry bits ADDR_W-1:12 followed by offset bits 11:0.
- R6: A data entry whose bit 0 is clear gives rsp_fault high with rsp_addr zero.
- R7: In translate mode an address below the input base faults in the cycle after acceptance, without any memory read.
- R8: The walker reads the next link (byte offset 0xFF8) when the target table is higher than the current one, and the previous link (byte offset 0xFF0) when it is lower, one hop per read. The current table is kept across requests and returns to table 0 at the table base whenever the block is idle and disabled.
- R9: A link whose bit 0 is clear ends the walk with a fault; the current table stays the last one reached.
- R10: A walk with h successful hops and one final read responds 2 + 2h cycles after acceptance; req_ready stays low until the response cycle has passed and rsp_valid lasts one cycle.
- R11: Entry bits 11:1 do not affect the translated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Read data for the selected register |
| req_valid | input | 1 | Translation request present |
| req_addr | input | ADDR_W | Input address |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_addr | output | ADDR_W | Translated or forwarded address, zero on fault |
| rsp_fault | output | 1 | Lookup failed |
| mem_req | output | 1 | Table entry read request (one cycle) |
| mem_addr | output | ADDR_W | Byte address of the 64-bit entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Table entry read back |
| stat_ready | output | 1 | Unit idle, safe to reconfigure |

## Verification
Responses that need no memory read (pass-through, and addresses below the base) are due in the first cycle after the accepting edge. Each memory read adds two cycles: one to issue it and one for the bench memory's registered answer. The bench therefore expects a walk to answer 2 + 2h cycles after acceptance and compares the measured count with this figure. It samples every output at the falling edge after the accepting edge and again at each later falling edge. It also checks that the number of reads equals the number of hops plus the final read, and that req_ready is low while the walk runs.

// File: rtl/chain_xlat_pkg.sv
// Shared constants and types for the linked table translator.
// Assumes 4 KB table pages of 64-bit entries and 1 MB per table.
package chain_xlat_pkg;
    localparam int PAGE_SHIFT  = 12;
    localparam int TABLE_SHIFT = 20;
    localparam int ENTRY_SHIFT = 3;
    localparam int SLOT_W      = PAGE_SHIFT - ENTRY_SHIFT;
    localparam int IDX_W       = TABLE_SHIFT - PAGE_SHIFT;
    localparam logic [SLOT_W-1:0] SLOT_BACK = SLOT_W'(510);
    localparam logic [SLOT_W-1:0] SLOT_FWD  = SLOT_W'(511);

    typedef enum logic [2:0] {
        W_IDLE, W_STEP, W_LINK, W_ENTRY, W_RESP
    } walk_st_t;

    typedef enum logic [1:0] {
        SEL_TBASE = 2'd0, SEL_IBASE = 2'd1, SEL_MODE = 2'd2, SEL_CTRL = 2'd3
    } cfg_sel_t;
endpackage

// File: rtl/chain_xlat_regs.sv
// Register set: table base, input base, mode, enable and ready status.
// Assumes the bases are page/table aligned; low bits are dropped on write.
// Base and mode writes are ignored while enable is set.
module chain_xlat_regs
    import chain_xlat_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              walk_idle,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic [ADDR_W-1:0] tbase,
    output logic [ADDR_W-1:0] ibase,
    output logic              xlat_mode,
    output logic              enable
);
    cfg_sel_t sel;
    assign sel = cfg_sel_t'(cfg_addr);

    // Register writes, with base and mode frozen while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbase     <= '0;
            ibase     <= '0;
            xlat_mode <= 1'b0;
            enable    <= 1'b0;
        end else if (cfg_we) begin
            case (sel)
                SEL_TBASE: if (!enable) tbase <= {cfg_wdata[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                SEL_IBASE: if (!enable) ibase <= {cfg_wdata[ADDR_W-1:TABLE_SHIFT], {TABLE_SHIFT{1'b0}}};
                SEL_MODE:  if (!enable) xlat_mode <= cfg_wdata[0];
                default:   enable <= cfg_wdata[0];
            endcase
        end
    end

    // Read multiplexer for the selected register.
    always_comb begin
        case (sel)
            SEL_TBASE: cfg_rdata = tbase;
            SEL_IBASE: cfg_rdata = ibase;
            SEL_MODE:  cfg_rdata = {{(ADDR_W-1){1'b0}}, xlat_mode};
            default:   cfg_rdata = {{(ADDR_W-2){1'b0}}, walk_idle, enable};
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^cfg_wdata[PAGE_SHIFT-1:1];

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($stable(tbase) && $stable(ibase) && $stable(xlat_mode))); // R2
endmodule

// File: rtl/chain_xlat_walker.sv
// Table walker: accepts one request at a time, follows prev/next links
// from the cached current table to the target table, reads the data entry
// and returns the translated address or a fault.
// Assumes memory answers each one-cycle read with one mem_rvalid pulse.
module chain_xlat_walker
    import chain_xlat_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              xlat_mode,
    input  logic [ADDR_W-1:0] tbase,
    input  logic [ADDR_W-1:0] ibase,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_fault,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              idle
);
    localparam int TN_W = ADDR_W - TABLE_SHIFT;
    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    walk_st_t              state;
    logic [PG_W-1:0]       cur_pg;
    logic [TN_W-1:0]       cur_tn;
    logic [TN_W-1:0]       tgt_tn;
    logic [IDX_W-1:0]      idx;
    logic [PAGE_SHIFT-1:0] pofs;
    logic [ADDR_W-1:0]     res_addr;
    logic                  res_fault;
    logic [ADDR_W-1:0]     offset;
    logic                  below;
    logic                  accept;
    logic [SLOT_W-1:0]     slot;

    assign offset    = req_addr - ibase;
    assign below     = req_addr < ibase;
    assign idle      = (state == W_IDLE);
    assign req_ready = enable && idle;
    assign accept    = req_valid && req_ready;
    assign rsp_valid = (state == W_RESP);
    assign rsp_addr  = res_addr;
    assign rsp_fault = res_fault;
    assign mem_req   = (state == W_STEP);

    // Slot to read: data entry at the target, else the link toward it.
    always_comb begin
        if (tgt_tn == cur_tn)     slot = {1'b0, idx};
        else if (tgt_tn > cur_tn) slot = SLOT_FWD;
        else                      slot = SLOT_BACK;
    end
    assign mem_addr = {cur_pg, slot, {ENTRY_SHIFT{1'b0}}};

    // Walk sequencer and current-table cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= W_IDLE;
            cur_pg    <= '0;
            cur_tn    <= '0;
            tgt_tn    <= '0;
            idx       <= '0;
            pofs      <= '0;
            res_addr  <= '0;
            res_fault <= 1'b0;
        end else begin
            case (state)
                W_IDLE: begin
                    if (!enable) begin
                        cur_pg <= tbase[ADDR_W-1:PAGE_SHIFT];
                        cur_tn <= '0;
                    end else if (req_valid) begin
                        if (!xlat_mode) begin
                            res_addr  <= req_addr;
                            res_fault <= 1'b0;
                            state     <= W_RESP;
                        end else if (below) begin
                            res_addr  <= '0;
                            res_fault <= 1'b1;
                            state     <= W_RESP;
                        end else begin
                            tgt_tn <= offset[ADDR_W-1:TABLE_SHIFT];
                            idx    <= offset[TABLE_SHIFT-1:PAGE_SHIFT];
                            pofs   <= offset[PAGE_SHIFT-1:0];
                            state  <= W_STEP;
                        end
                    end
                end
                W_STEP: state <= (tgt_tn == cur_tn) ? W_ENTRY : W_LINK;
                W_LINK: begin
                    if (mem_rvalid) begin
                        if (!mem_rdata[0]) begin
                            res_addr  <= '0;
                            res_fault <= 1'b1;
                            state     <= W_RESP;
                        end else begin
                            cur_pg <= mem_rdata[ADDR_W-1:PAGE_SHIFT];
                            cur_tn <= (tgt_tn > cur_tn) ? cur_tn + TN_W'(1) : cur_tn - TN_W'(1);
                            state  <= W_STEP;
                        end
                    end
                end
                W_ENTRY: begin
                    if (mem_rvalid) begin
                        res_fault <= !mem_rdata[0];
                        res_addr  <= mem_rdata[0] ? {mem_rdata[ADDR_W-1:PAGE_SHIFT], pofs} : '0;
                        state     <= W_RESP;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    logic unused_bits;
    assign unused_bits = ^{mem_rdata[63:ADDR_W], mem_rdata[PAGE_SHIFT-1:1], tbase[PAGE_SHIFT-1:0]};

    AST_PASS_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !xlat_mode) |=> (rsp_valid && !rsp_fault && rsp_addr == $past(req_addr))); // R4
    AST_BELOW_BASE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && xlat_mode && below) |=> (rsp_valid && rsp_fault && !mem_req)); // R7
    AST_LINK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_LINK && mem_rvalid && !mem_rdata[0]) |=> (rsp_valid && rsp_fault && rsp_addr == '0)); // R9
    AST_ONE_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_LINK && mem_rvalid && mem_rdata[0]) |=>
            ((cur_tn - $past(cur_tn)) == TN_W'(1) || ($past(cur_tn) - cur_tn) == TN_W'(1))); // R8
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R10
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
endmodule

// File: rtl/chain_xlat.sv
// Top of the linked table translator: register set plus table walker.
// Assumes a memory port that answers each read with one mem_rvalid pulse.
module chain_xlat
    import chain_xlat_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_fault,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              stat_ready
);
    logic [ADDR_W-1:0] tbase;
    logic [ADDR_W-1:0] ibase;
    logic              xlat_mode;
    logic              enable;
    logic              walk_idle;

    chain_xlat_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .walk_idle(walk_idle), .cfg_rdata(cfg_rdata),
        .tbase(tbase), .ibase(ibase), .xlat_mode(xlat_mode), .enable(enable)
    );

    chain_xlat_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .enable(enable), .xlat_mode(xlat_mode),
        .tbase(tbase), .ibase(ibase), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .idle(walk_idle)
    );

    assign stat_ready = walk_idle;
endmodule

// File: tb/tb_chain_xlat.sv
`timescale 1ns/1ps
module tb_chain_xlat;
    localparam int AW = 40;
    localparam logic [AW-1:0] IB  = 40'h10_0000;
    localparam logic [AW-1:0] TB0 = 40'h8_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, rsp_valid, rsp_fault, mem_req, stat_ready;
    logic [AW-1:0] rsp_addr, mem_addr;
    logic mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int mreads = 0;

    always #2 clk = ~clk;

    chain_xlat #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .stat_ready(stat_ready)
    );

    // Data page address for table t, entry s.
    function automatic logic [AW-1:0] dpage(input int t, input int s);
        return 40'h4000_0000 + AW'((t * 256 + s) * 32'h2000);
    endfunction

    // Memory image: three linked tables; table 2 holds only 10 valid entries;
    // table 1 entries carry a nonzero bit 5 that must be ignored.
    function automatic logic [63:0] mem_image(input logic [AW-1:0] a);
        int k;
        int slot;
        logic [63:0] v;
        v = '0;
        slot = int'(a[11:3]);
        for (int t = 0; t < 3; t++) begin
            if (a[AW-1:12] == (TB0[AW-1:12] + AW'(t * 16))) begin
                k = t;
                if (slot < 256) begin
                    if (k < 2 || slot < 10)
                        v = 64'(dpage(k, slot)) | 64'h1 | ((k == 1) ? 64'h20 : 64'h0);
                end else if (slot == 510) begin
                    if (k > 0) v = 64'(TB0 + AW'((k - 1) * 32'h1_0000)) | 64'h1;
                end else if (slot == 511) begin
                    if (k < 2) v = 64'(TB0 + AW'((k + 1) * 32'h1_0000)) | 64'h1;
                end
            end
        end
        return v;
    endfunction

    // Bench memory: one-cycle registered answer; counts reads.
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem_req ? mem_image(mem_addr) : 64'h0;
        if (mem_req) mreads <= mreads + 1;
    end

    task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [AW-1:0] d);
        @(negedge clk);
        cfg_addr = sel;
        #1 d = cfg_rdata;
    endtask

    // Issue one request; return latency in cycles after acceptance and reads.
    task automatic do_req(input logic [AW-1:0] a, output int lat, output int nrd,
                          output logic busy_seen);
        int r0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        r0 = mreads;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_seen = !req_ready;
        lat = 0;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        nrd = mreads - r0;
    endtask

    typedef struct packed {
        logic [AW-1:0] a;
        logic          f;
        logic [3:0]    lat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{40'h10_0123, 1'b0, 4'd2},  // R5 table 0 first entry
        '{40'h1F_F456, 1'b0, 4'd2},  // R5 table 0 last entry
        '{40'h20_0010, 1'b0, 4'd4},  // R8 R11 one hop forward
        '{40'h30_5ABC, 1'b0, 4'd4},  // R8 one hop forward
        '{40'h30_9000, 1'b0, 4'd2},  // R5 last valid entry
        '{40'h30_A000, 1'b1, 4'd2},  // R6 invalid data entry
        '{40'h40_0000, 1'b1, 4'd2},  // R9 missing next link
        '{40'h10_0000, 1'b0, 4'd6},  // R8 two hops back
        '{40'h0F_FFFF, 1'b1, 4'd0},  // R7 below base
        '{40'h2F_F000, 1'b0, 4'd4},  // R11 table 1 last entry
        '{40'h10_00FF, 1'b0, 4'd4},  // R8 one hop back
        '{40'hF0_0000, 1'b1, 4'd6}   // R9 two hops then missing link
    };

    function automatic logic [AW-1:0] exp_phys(input logic [AW-1:0] a);
        logic [AW-1:0] off;
        off = a - IB;
        return dpage(int'(off[AW-1:20]), int'(off[19:12])) | {28'h0, off[11:0]};
    endfunction

    initial begin
        #(100000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] rd;
        int lat, nrd;
        logic busy;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rsp_valid", rsp_valid == 1'b0, rsp_valid, 0);
        check("R1 mem_req", mem_req == 1'b0, mem_req, 0);
        check("R1 stat_ready", stat_ready == 1'b1, stat_ready, 1);
        check("R1 req_ready", req_ready == 1'b0, req_ready, 0);
        cfg_read(2'd3, rd); check("R1 ctrl", rd == 40'h2, rd, 2);
        cfg_read(2'd2, rd); check("R1 mode", rd == 40'h0, rd, 0);
        cfg_read(2'd0, rd); check("R1 tbase", rd == 40'h0, rd, 0);

        // R2 alignment of bases
        cfg_write(2'd0, TB0 | 40'hFFF);
        cfg_write(2'd1, 40'h1A_BCDE);
        cfg_read(2'd0, rd); check("R2 tbase align", rd == TB0, rd, TB0);
        cfg_read(2'd1, rd); check("R2 ibase align", rd == IB, rd, IB);

        // R3 disabled: no acceptance, no response
        @(negedge clk);
        req_valid = 1'b1; req_addr = 40'h10_0000;
        repeat (3) @(negedge clk);
        check("R3 no response when disabled", rsp_valid == 1'b0 && req_ready == 1'b0, rsp_valid, 0);
        req_valid = 1'b0;

        cfg_write(2'd2, 40'h1);
        cfg_write(2'd3, 40'h1);

        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].a, lat, nrd, busy);
            check("R6 fault", rsp_fault == VECS[i].f, rsp_fault, VECS[i].f);
            check("R5 address", rsp_addr == (VECS[i].f ? '0 : exp_phys(VECS[i].a)),
                  rsp_addr, VECS[i].f ? '0 : exp_phys(VECS[i].a));
            check("R10 latency", lat == int'(VECS[i].lat), lat, VECS[i].lat);
            check("R8 reads", nrd == int'(VECS[i].lat) / 2, nrd, VECS[i].lat / 2);
            if (VECS[i].lat != 0)
                check("R10 busy during walk", busy == 1'b1, busy, 1);
            @(negedge clk);
            check("R10 ready after response", req_ready == 1'b1 && rsp_valid == 1'b0, req_ready, 1);
        end

        // R2 writes ignored while enabled
        cfg_write(2'd0, 40'h12_3000);
        cfg_write(2'd2, 40'h0);
        cfg_read(2'd0, rd); check("R2 tbase frozen", rd == TB0, rd, TB0);
        cfg_read(2'd2, rd); check("R2 mode frozen", rd == 40'h1, rd, 1);

        // R8 cache returns to table 0 after disable/enable (was table 2)
        cfg_write(2'd3, 40'h0);
        cfg_write(2'd3, 40'h1);
        do_req(40'h10_0010, lat, nrd, busy);
        check("R8 cache reset latency", lat == 2, lat, 2);
        check("R8 cache reset addr", rsp_addr == exp_phys(40'h10_0010), rsp_addr, exp_phys(40'h10_0010));

        // R4 pass-through
        cfg_write(2'd3, 40'h0);
        cfg_write(2'd2, 40'h0);
        cfg_write(2'd3, 40'h1);
        do_req(40'h12_3456, lat, nrd, busy);
        check("R4 pass addr", rsp_addr == 40'h12_3456, rsp_addr, 40'h12_3456);
        check("R4 pass fault", rsp_fault == 1'b0, rsp_fault, 0);
        check("R4 pass latency", lat == 0, lat, 0);
        check("R4 pass no read", nrd == 0, nrd, 0);
        do_req(40'h0_0010, lat, nrd, busy);
        check("R4 pass below base", rsp_addr == 40'h10 && !rsp_fault, rsp_addr, 40'h10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule